// File: doc/BRIEF.md
# SPI byte-wide data register front end

This block is the bus-facing data register of an SPI peripheral. An 8-bit register bus reaches a 16-bit transmit word and a 16-bit receive word through two byte addresses: a low byte and a high byte. A status byte at a third address reports whether the transmit word is empty and whether the receive word is full. The serial shift engine is not part of the block. It shows up only as three signals: a strobe when it takes the transmit word, a strobe when a transfer completes, and the word it received.

In 8-bit mode only the low byte is live. In 16-bit mode, byte accesses are made coherent. The first byte read freezes the whole receive word in a read latch, and the read of the partner byte releases it. Byte writes are staged until both halves are present, and then move to the transmit word together. A completed transfer that finds the receive word still unread is dropped without any indication.

Writes reach the transmit word in one of two ways. The first is a processor path: a status read made while the transmit word is empty arms exactly one word write. The second is a DMA path: while DMA is enabled and the transmit word is empty, a request is raised and writes are taken without any status read.

Top module: `spi_dreg`

## Requirements
- R1: After reset the transmit word is 0, transmit-empty is 1, receive-full is 0, the DMA request is 0, and the low and high data bytes read as 0.
- R2: The low data byte is at address 6, the high data byte at address 7, and the status byte at address 3. Status bit 0 is transmit-empty, bit 1 is receive-full, and all other status bits read 0.
- R3: In 8-bit mode (mode16_i=0), the high byte reads as 0 and writes to it are ignored. An accepted low-byte write sets the transmit word to {8'h00, data}.
- R4: In 16-bit mode, the first data byte read captures the whole receive word in a latch. Repeated reads of the same byte keep the latch. A read of the other byte returns the latched half and releases the latch.
- R5: In 16-bit mode, accepted byte writes are staged, in either order. The transmit word changes only when both bytes have been written, and then it takes both bytes at once.
- R6: A transfer completion while receive-full is 0 stores rx_word_i and sets receive-full. Receive-full clears on a low-byte read in 8-bit mode, or on the read that releases the latch in 16-bit mode.
- R7: A transfer completion while receive-full is 1 is discarded. The old word is kept, and nothing else changes.
- R8: With DMA disabled, data writes are accepted only after a status read made while transmit-empty was 1. Other data writes are ignored. One such read allows one word.
- R9: dma_req_o is 1 exactly while dma_en_i and transmit-empty are both 1. While it is 1, data writes are accepted without a status read.
- R10: Transmit-empty clears when a word enters the transmit buffer. It sets on tx_load_i while it is 0. While it is 0, the transmit word holds.
- R11: A change of mode16_i clears the read latch and any partly staged write on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| dma_en_i | input | 1 | Transmit DMA enable |
| addr_i | input | 3 | Register byte address |
| rd_en_i | input | 1 | Bus read strobe |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data for addr_i (combinational) |
| txe_o | output | 1 | Transmit word empty |
| rxf_o | output | 1 | Receive word full |
| dma_req_o | output | 1 | Transmit DMA request |
| tx_load_i | input | 1 | Shift engine takes the transmit word |
| tx_word_o | output | 16 | Transmit word to the shift engine |
| xfer_done_i | input | 1 | Shift engine finished a transfer |
| rx_word_i | input | 16 | Word received by the shift engine |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and addresses 6, 7 and 3. With these values, every byte address, both modes and the full 16-bit word space are reachable from the bus. Random 16-bit words are received and transmitted with a random byte order and a random choice between the DMA and processor paths. Directed sequences then cover overrun, re-reading one latched byte, unarmed writes, and mode switches in the middle of a latched read or a staged write.

// File: rtl/spi_dreg_pkg.sv
package spi_dreg_pkg;
  localparam int unsigned TXE_BIT = 0;
  localparam int unsigned RXF_BIT = 1;

  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic rd_st;
    logic wr_lo;
    logic wr_hi;
  } dreg_acc_t;
endpackage

// File: rtl/spi_dreg_rx.sv
module spi_dreg_rx
  import spi_dreg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              mode_chg_i,
  input  dreg_acc_t         acc_i,
  input  logic              xfer_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              rxf_o,
  output logic [BYTE_W-1:0] lo_byte_o,
  output logic [BYTE_W-1:0] hi_byte_o
);
  logic [WORD_W-1:0] rx_q, lat_q;
  logic              rxf_q, lat_v_q, lat_hi_first_q;
  logic              rx_clr;
  logic              lat_open, lat_close;

  // 16-bit latch control
  assign lat_open  = mode16_i && !mode_chg_i && !lat_v_q && (acc_i.rd_lo || acc_i.rd_hi);
  assign lat_close = mode16_i && !mode_chg_i && lat_v_q &&
                     ((acc_i.rd_lo && lat_hi_first_q) || (acc_i.rd_hi && !lat_hi_first_q));
  assign rx_clr    = lat_close || (!mode16_i && !mode_chg_i && acc_i.rd_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      rxf_q <= 1'b0;
    end else begin
      if (xfer_done_i && !rxf_q) begin
        rx_q  <= rx_word_i;
        rxf_q <= 1'b1;
      end else if (rx_clr) begin
        rxf_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q          <= '0;
      lat_v_q        <= 1'b0;
      lat_hi_first_q <= 1'b0;
    end else if (mode_chg_i) begin
      lat_v_q <= 1'b0;
    end else if (lat_open) begin
      lat_q          <= rx_q;
      lat_v_q        <= 1'b1;
      lat_hi_first_q <= acc_i.rd_hi;
    end else if (lat_close) begin
      lat_v_q <= 1'b0;
    end
  end

  always_comb begin
    if (mode16_i && lat_v_q) begin
      lo_byte_o = lat_q[BYTE_W-1:0];
      hi_byte_o = lat_q[WORD_W-1:BYTE_W];
    end else begin
      lo_byte_o = rx_q[BYTE_W-1:0];
      hi_byte_o = mode16_i ? rx_q[WORD_W-1:BYTE_W] : '0;
    end
  end

  assign rxf_o = rxf_q;
endmodule

// File: rtl/spi_dreg_tx.sv
module spi_dreg_tx
  import spi_dreg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              mode_chg_i,
  input  logic              dma_en_i,
  input  dreg_acc_t         acc_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tx_load_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              txe_o
);
  logic [BYTE_W-1:0] stg_lo_q, stg_hi_q;
  logic              stg_lo_v_q, stg_hi_v_q;
  logic [WORD_W-1:0] tx_q, commit_word;
  logic              txe_q, armed_q;
  logic              allowed, commit8, commit16, commit;

  assign allowed  = txe_q && (dma_en_i || armed_q) && !mode_chg_i;
  assign commit8  = !mode16_i && allowed && acc_i.wr_lo;
  assign commit16 = mode16_i && allowed &&
                    ((acc_i.wr_lo && stg_hi_v_q) || (acc_i.wr_hi && stg_lo_v_q));
  assign commit   = commit8 || commit16;

  always_comb begin
    if (!mode16_i)        commit_word = {{BYTE_W{1'b0}}, wdata_i};
    else if (acc_i.wr_lo) commit_word = {stg_hi_q, wdata_i};
    else                  commit_word = {wdata_i, stg_lo_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_lo_q   <= '0;
      stg_hi_q   <= '0;
      stg_lo_v_q <= 1'b0;
      stg_hi_v_q <= 1'b0;
    end else if (mode_chg_i || commit) begin
      stg_lo_v_q <= 1'b0;
      stg_hi_v_q <= 1'b0;
    end else if (mode16_i && allowed) begin
      if (acc_i.wr_lo) begin
        stg_lo_q   <= wdata_i;
        stg_lo_v_q <= 1'b1;
      end
      if (acc_i.wr_hi) begin
        stg_hi_q   <= wdata_i;
        stg_hi_v_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      txe_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (commit) begin
        tx_q    <= commit_word;
        txe_q   <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        if (tx_load_i && !txe_q)     txe_q   <= 1'b1;
        if (acc_i.rd_st && txe_q)    armed_q <= 1'b1;
      end
    end
  end

  assign tx_word_o = tx_q;
  assign txe_o     = txe_q;
endmodule

// File: rtl/spi_dreg.sv
module spi_dreg
  import spi_dreg_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned LO_ADDR   = 6,
  parameter int unsigned HI_ADDR   = 7,
  parameter int unsigned STAT_ADDR = 3,
  localparam int unsigned WORD_W   = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              dma_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              txe_o,
  output logic              rxf_o,
  output logic              dma_req_o,
  input  logic              tx_load_i,
  output logic [WORD_W-1:0] tx_word_o,
  input  logic              xfer_done_i,
  input  logic [WORD_W-1:0] rx_word_i
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STAT_ADDR);

  dreg_acc_t         acc;
  logic              mode_q, mode_chg;
  logic [BYTE_W-1:0] lo_byte, hi_byte, stat_byte;

  always_comb begin
    acc.rd_lo = rd_en_i && (addr_i == A_LO);
    acc.rd_hi = rd_en_i && (addr_i == A_HI);
    acc.rd_st = rd_en_i && (addr_i == A_ST);
    acc.wr_lo = wr_en_i && (addr_i == A_LO);
    acc.wr_hi = wr_en_i && (addr_i == A_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode16_i;
  end
  assign mode_chg = mode_q != mode16_i;

  spi_dreg_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode16_i    (mode16_i),
    .mode_chg_i  (mode_chg),
    .acc_i       (acc),
    .xfer_done_i (xfer_done_i),
    .rx_word_i   (rx_word_i),
    .rxf_o       (rxf_o),
    .lo_byte_o   (lo_byte),
    .hi_byte_o   (hi_byte)
  );

  spi_dreg_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode16_i   (mode16_i),
    .mode_chg_i (mode_chg),
    .dma_en_i   (dma_en_i),
    .acc_i      (acc),
    .wdata_i    (wdata_i),
    .tx_load_i  (tx_load_i),
    .tx_word_o  (tx_word_o),
    .txe_o      (txe_o)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[TXE_BIT] = txe_o;
    stat_byte[RXF_BIT] = rxf_o;
  end

  always_comb begin
    unique case (addr_i)
      A_LO:    rdata_o = lo_byte;
      A_HI:    rdata_o = hi_byte;
      A_ST:    rdata_o = stat_byte;
      default: rdata_o = '0;
    endcase
  end

  assign dma_req_o = dma_en_i && txe_o;
endmodule

// File: rtl/spi_dreg_chk.sv
module spi_dreg_chk #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned HI_ADDR   = 7,
  parameter int unsigned STAT_ADDR = 3,
  localparam int unsigned WORD_W   = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode16_i,
  input logic              dma_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              txe_o,
  input logic              rxf_o,
  input logic              dma_req_o,
  input logic              tx_load_i,
  input logic [WORD_W-1:0] tx_word_o,
  input logic              xfer_done_i
);
  p_hi_zero_8b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode16_i && rd_en_i && addr_i == ADDR_W'(HI_ADDR)) |-> rdata_o == '0);

  p_stat_pad_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(STAT_ADDR)) |-> rdata_o[BYTE_W-1:2] == '0);

  p_rxf_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !rxf_o) |=> rxf_o);

  p_dma_req_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (txe_o && dma_en_i));

  p_txe_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_o && tx_load_i) |=> txe_o);

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_o && !tx_load_i) |=> $stable(tx_word_o));

  p_commit_clears_txe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_word_o) |-> !txe_o);
endmodule

bind spi_dreg spi_dreg_chk #(
  .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode16_i    (mode16_i),
  .dma_en_i    (dma_en_i),
  .addr_i      (addr_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .txe_o       (txe_o),
  .rxf_o       (rxf_o),
  .dma_req_o   (dma_req_o),
  .tx_load_i   (tx_load_i),
  .tx_word_o   (tx_word_o),
  .xfer_done_i (xfer_done_i)
);

// File: tb/spi_dreg_test.sv
module spi_dreg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_LO = 3'd6;
  localparam logic [2:0] A_HI = 3'd7;
  localparam logic [2:0] A_ST = 3'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b0, dma_en = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic        txe, rxf, dma_req;
  logic        tx_load = 1'b0, xfer_done = 1'b0;
  logic [15:0] tx_word, rx_word = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dreg uut (
    .clk_i(clk), .rst_ni(rst_n), .mode16_i(mode16), .dma_en_i(dma_en),
    .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .txe_o(txe), .rxf_o(rxf), .dma_req_o(dma_req),
    .tx_load_i(tx_load), .tx_word_o(tx_word), .xfer_done_i(xfer_done),
    .rx_word_i(rx_word)
  );

  function automatic logic [15:0] exp_tx8(input logic [7:0] b);
    return {8'h00, b};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] w, input bit hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [7:0] exp_stat(input bit e, input bit f);
    return {6'b0, f, e};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] w);
    rx_word = w; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
  endtask

  task automatic load();
    tx_load = 1'b1;
    tick();
    tx_load = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    mode16 = m;
    tick(); tick();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] w;
    void'($urandom(32'd5150));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_word", tx_word, 16'h0);
    chk("R1 txe", txe, 1);
    chk("R1 rxf", rxf, 0);
    chk("R1 dma_req", dma_req, 0);
    bus_rd(A_LO, d); chk("R1 lo byte", d, 8'h00);

    // R8 unarmed write ignored
    bus_wr(A_LO, 8'h5A);
    chk("R8 unarmed tx_word", tx_word, 16'h0);
    chk("R8 unarmed txe", txe, 1);
    bus_rd(A_ST, d); chk("R2 status empty", d, exp_stat(1, 0));
    bus_wr(A_LO, 8'hA5);
    chk("R3 8b low write", tx_word, exp_tx8(8'hA5));
    chk("R10 txe cleared", txe, 0);
    bus_rd(A_ST, d); chk("R2 status full tx", d, exp_stat(0, 0));
    bus_wr(A_HI, 8'hFF);
    chk("R3 8b high write ignored", tx_word, exp_tx8(8'hA5));
    load();
    chk("R10 txe set by load", txe, 1);
    bus_wr(A_LO, 8'h3C);
    chk("R8 one arm per word", tx_word, exp_tx8(8'hA5));
    chk("R8 txe unchanged", txe, 1);

    // R6/R3 receive in 8-bit mode
    xfer(16'h1234);
    chk("R6 rxf set", rxf, 1);
    bus_rd(A_ST, d); chk("R2 status both", d, exp_stat(1, 1));
    bus_rd(A_HI, d); chk("R3 8b high reads zero", d, 8'h00);
    chk("R6 rxf kept after high read", rxf, 1);
    bus_rd(A_LO, d); chk("R6 8b low data", d, 8'h34);
    chk("R6 rxf cleared", rxf, 0);

    // R7 overrun
    xfer(16'h5678);
    xfer(16'h9ABC);
    chk("R7 rxf still set", rxf, 1);
    bus_rd(A_ST, d); chk("R7 no extra status", d, exp_stat(1, 1));
    bus_rd(A_LO, d); chk("R7 old data kept", d, 8'h78);

    // R9/R5 DMA path in 16-bit mode
    set_mode(1'b1);
    dma_en = 1'b1;
    #1 chk("R9 dma_req on", dma_req, 1);
    bus_wr(A_HI, 8'hDE);
    chk("R5 half staged", tx_word, exp_tx8(8'hA5));
    chk("R5 txe during staging", txe, 1);
    bus_wr(A_LO, 8'hAD);
    chk("R5 coherent word", tx_word, 16'hDEAD);
    chk("R9 dma_req off", dma_req, 0);
    load();

    // R4 read latch
    xfer(16'hC3E1);
    bus_rd(A_LO, d); chk("R4 first low", d, 8'hE1);
    chk("R4 rxf during latch", rxf, 1);
    bus_rd(A_LO, d); chk("R4 repeat low", d, 8'hE1);
    chk("R4 repeat keeps latch", rxf, 1);
    bus_rd(A_HI, d); chk("R4 partner high", d, 8'hC3);
    chk("R6 16b release clears rxf", rxf, 0);

    // R11 mode change clears latch
    xfer(16'h7F80);
    bus_rd(A_LO, d); chk("R4 latch low", d, 8'h80);
    set_mode(1'b0);
    set_mode(1'b1);
    bus_rd(A_HI, d); chk("R11 new latch high", d, 8'h7F);
    chk("R11 latch was cleared", rxf, 1);
    bus_rd(A_LO, d); chk("R11 release low", d, 8'h80);
    chk("R11 rxf cleared", rxf, 0);

    // R11 mode change clears staging
    bus_wr(A_HI, 8'h11);
    set_mode(1'b0);
    set_mode(1'b1);
    bus_wr(A_LO, 8'h22);
    chk("R11 staging dropped", tx_word, 16'hDEAD);
    bus_wr(A_HI, 8'h33);
    chk("R11 fresh pair", tx_word, 16'h3322);
    load();

    // R8 16-bit processor path
    dma_en = 1'b0;
    bus_wr(A_LO, 8'h44);
    bus_wr(A_HI, 8'h55);
    chk("R8 16b unarmed ignored", tx_word, 16'h3322);
    bus_rd(A_ST, d);
    bus_wr(A_LO, 8'h66);
    bus_wr(A_HI, 8'h77);
    chk("R8 16b armed word", tx_word, 16'h7766);
    load();

    // random mix
    for (int i = 0; i < 150; i++) begin
      bit hi_first, use_dma;
      w = 16'($urandom);
      hi_first = 1'($urandom);
      xfer(w);
      chk("R6 rand rxf", rxf, 1);
      bus_rd(hi_first ? A_HI : A_LO, d);
      chk("R4 rand first", d, pick_byte(w, hi_first));
      bus_rd(hi_first ? A_LO : A_HI, d);
      chk("R4 rand second", d, pick_byte(w, !hi_first));
      chk("R6 rand rxf clear", rxf, 0);

      w = 16'($urandom);
      hi_first = 1'($urandom);
      use_dma = 1'($urandom);
      dma_en = use_dma;
      if (!use_dma) bus_rd(A_ST, d);
      bus_wr(hi_first ? A_HI : A_LO, pick_byte(w, hi_first));
      bus_wr(hi_first ? A_LO : A_HI, pick_byte(w, !hi_first));
      chk("R5 rand tx word", tx_word, w);
      chk("R10 rand txe", txe, 0);
      load();
    end

    done = 1'b1;
    finish_run();
  end
endmodule